// File: doc/BRIEF.md
# UART Modem Control and Status Registers

This block is the modem-side register pair of a 16550-compatible serial port. A write-only control register sets the four active-low handshake outputs (terminal-ready, request-to-send and two general-purpose outputs) and a loopback switch. A readable status register reports the live level of the four active-low modem inputs (clear-to-send, set-ready, ring, carrier-detect). It also latches a sticky change flag for each input until the CPU reads the register.

The modem inputs are asynchronous. They pass through a two-stage synchronizer before any change detection. In loopback, all four outputs are held inactive, and the control bits drive the status inputs internally instead of the external pins. The block requests a modem-status interrupt whenever a change flag is set and the enable input is high. It also drives a transceiver disable pin that goes low for the duration of any CPU read.

There is no data stream at this boundary. The CPU side is a plain one-cycle strobe interface with a one-bit register select, and every pin is plain control or status with no back-pressure.

Top module: `modem_port_regs`

## Requirements
- R1: After reset the control register is zero, all four modem outputs are high, the status read returns 0x00 (with all inputs held high), `irq_o` is low and `drv_dis_o` is high.
- R2: A write with `cpu_sel_i`=0 loads the control register: bit0 terminal-ready, bit1 request-to-send, bit2 general output 1, bit3 general output 2. While bit4 is 0, each output pin is the inverse of its bit, so a 1 drives the pin low. A read with `cpu_sel_i`=0 returns 0x00.
- R3: While control bit4 (loopback) is 1, all four modem outputs are high, whatever bits 3:0 hold.
- R4: Status bits 7, 6, 5 and 4 read 1 exactly when carrier-detect, ring, set-ready and clear-to-send, respectively, are active (pin low).
- R5: Status bits 0 (clear-to-send), 1 (set-ready) and 3 (carrier-detect) set on any level change of their input and stay set until a status read.
- R6: Status bit 2 sets only when ring goes from active to inactive. A change from inactive to active leaves it unchanged.
- R7: A status read (`cpu_rd_i`=1, `cpu_sel_i`=1) returns the byte and clears bits 3:0 at the clock edge that ends the read. A change that is detected at that same edge is still recorded.
- R8: In loopback the status inputs are taken from the control bits: clear-to-send from bit1, set-ready from bit0, ring from bit2, carrier-detect from bit3. The external modem pins are ignored.
- R9: `irq_o` is high exactly when `irq_en_i` is high and any of status bits 3:0 is set. It therefore drops after a status read that clears them.
- R10: `drv_dis_o` is low while `cpu_rd_i` is high, and high otherwise.
- R11: An external pin change appears in the status level bits after two clock edges and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous master reset, active low |
| cpu_sel_i | input | 1 | Register select: 0 control, 1 status |
| cpu_wr_i | input | 1 | Write strobe, one cycle per write |
| cpu_rd_i | input | 1 | Read strobe, one cycle per read |
| cpu_wdata_i | input | 5 | Write data for the control register |
| cpu_rdata_o | output | 8 | Read data for the selected register |
| irq_en_i | input | 1 | Modem-status interrupt enable |
| irq_o | output | 1 | Modem-status interrupt request, active high |
| drv_dis_o | output | 1 | Transceiver disable, low during a CPU read |
| cts_n_i | input | 1 | Clear-to-send, active low |
| dsr_n_i | input | 1 | Data-set-ready, active low |
| ri_n_i | input | 1 | Ring indicator, active low |
| dcd_n_i | input | 1 | Carrier detect, active low |
| dtr_n_o | output | 1 | Terminal-ready, active low |
| rts_n_o | output | 1 | Request-to-send, active low |
| out1_n_o | output | 1 | General output 1, active low |
| out2_n_o | output | 1 | General output 2, active low |

## Verification
A corrupted change flag or previous-level register shows up at `irq_o` as soon as it is wrong. It also shows up in bits 3:0 of the next status read, within one cycle of the read strobe. A wrong synchronizer stage or loopback selection shows in status bits 7:4 two edges after the stimulus. Sweeping every pair of input patterns, with a read after each step, shows that a flag lost or falsely set appears on the very next read. A control register fault is visible on the output pins in the cycle after the write.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned CTL_W     = 5;
  localparam int unsigned STAT_W    = 2 * NUM_LINES;

  // modem input line positions (shared by level and change fields)
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;

  // control register bit positions
  localparam int unsigned CB_DTR  = 0;
  localparam int unsigned CB_RTS  = 1;
  localparam int unsigned CB_OUT1 = 2;
  localparam int unsigned CB_OUT2 = 3;
  localparam int unsigned CB_LOOP = 4;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [CTL_W-1:0]     wdata_i,
  output logic [CTL_W-1:0]     ctl_o,
  output logic                 loop_o,
  output logic [NUM_LINES-1:0] pins_n_o
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ctl_q <= '0;
    else if (wr_i) ctl_q <= wdata_i;
  end

  assign ctl_o  = ctl_q;
  assign loop_o = ctl_q[CB_LOOP];

  // outputs idle (high) during loopback, else inverse of their bit
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_pin
    assign pins_n_o[i] = ctl_q[CB_LOOP] | ~ctl_q[i];
  end
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_act_i,
  input  logic                 rd_clr_i,
  output logic [STAT_W-1:0]    status_o,
  output logic [NUM_LINES-1:0] set_o,
  output logic                 any_delta_o
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] delta_q;
  logic [NUM_LINES-1:0] set_w;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i == LN_RI) begin : g_trail
      assign set_w[i] = prev_q[i] & ~line_act_i[i];
    end else begin : g_any
      assign set_w[i] = prev_q[i] ^ line_act_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= line_act_i;
      delta_q <= (rd_clr_i ? '0 : delta_q) | set_w;
    end
  end

  assign status_o    = {line_act_i, delta_q};
  assign set_o       = set_w;
  assign any_delta_o = |delta_q;

  // R6: ring turning active never raises its change flag
  assert_ri_trailing_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_q[LN_RI] && line_act_i[LN_RI] && !delta_q[LN_RI]) |=> !delta_q[LN_RI]);

  // R7: a change detected at the clearing edge survives the read
  assert_read_keeps_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && (|set_w)) |=> (delta_q != '0));
endmodule

// File: rtl/modem_port_regs.sv
module modem_port_regs
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_sel_i,
  input  logic             cpu_wr_i,
  input  logic             cpu_rd_i,
  input  logic [CTL_W-1:0] cpu_wdata_i,
  output logic [7:0]       cpu_rdata_o,
  input  logic             irq_en_i,
  output logic             irq_o,
  output logic             drv_dis_o,
  input  logic             cts_n_i,
  input  logic             dsr_n_i,
  input  logic             ri_n_i,
  input  logic             dcd_n_i,
  output logic             dtr_n_o,
  output logic             rts_n_o,
  output logic             out1_n_o,
  output logic             out2_n_o
);
  logic [CTL_W-1:0]     ctl_w;
  logic                 loop_w;
  logic [NUM_LINES-1:0] pins_n_w;
  logic [NUM_LINES-1:0] ext_n_w;
  logic [NUM_LINES-1:0] ext_sync_n_w;
  logic [NUM_LINES-1:0] lb_act_w;
  logic [NUM_LINES-1:0] line_act_w;
  logic [NUM_LINES-1:0] set_w;
  logic [STAT_W-1:0]    status_w;
  logic                 any_delta_w;
  logic                 rd_stat_w;

  mdm_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cpu_wr_i & ~cpu_sel_i),
    .wdata_i  (cpu_wdata_i),
    .ctl_o    (ctl_w),
    .loop_o   (loop_w),
    .pins_n_o (pins_n_w)
  );

  assign dtr_n_o  = pins_n_w[CB_DTR];
  assign rts_n_o  = pins_n_w[CB_RTS];
  assign out1_n_o = pins_n_w[CB_OUT1];
  assign out2_n_o = pins_n_w[CB_OUT2];

  assign ext_n_w[LN_CTS] = cts_n_i;
  assign ext_n_w[LN_DSR] = dsr_n_i;
  assign ext_n_w[LN_RI]  = ri_n_i;
  assign ext_n_w[LN_DCD] = dcd_n_i;

  mdm_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ext_n_w),
    .q_o   (ext_sync_n_w)
  );

  assign lb_act_w[LN_CTS] = ctl_w[CB_RTS];
  assign lb_act_w[LN_DSR] = ctl_w[CB_DTR];
  assign lb_act_w[LN_RI]  = ctl_w[CB_OUT1];
  assign lb_act_w[LN_DCD] = ctl_w[CB_OUT2];

  assign line_act_w = loop_w ? lb_act_w : ~ext_sync_n_w;
  assign rd_stat_w  = cpu_rd_i & cpu_sel_i;

  mdm_status i_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_act_i  (line_act_w),
    .rd_clr_i    (rd_stat_w),
    .status_o    (status_w),
    .set_o       (set_w),
    .any_delta_o (any_delta_w)
  );

  assign cpu_rdata_o = cpu_sel_i ? status_w : '0;
  assign irq_o       = irq_en_i & any_delta_w;
  assign drv_dis_o   = ~cpu_rd_i;

  // R3: loopback keeps every modem output idle
  assert_lb_outputs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_w |-> (dtr_n_o && rts_n_o && out1_n_o && out2_n_o));

  // R9: a detected change with the enable held raises the request
  assert_irq_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_i && (|set_w)) |=> (irq_o || !irq_en_i));

  // R9: a status read with no fresh change drops the request
  assert_irq_clear_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_w && (set_w == '0)) |=> !irq_o);
endmodule

// File: tb/test_modem_port_regs.sv
`timescale 1ns/1ps
module test_modem_port_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [4:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       irq_en = 1'b0, irq, drv_dis;
  logic [3:0] pin_n = 4'hF; // {dcd, ri, dsr, cts}
  logic       dtr_n, rts_n, out1_n, out2_n;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  logic [4:0] m_ctl = '0;
  logic [3:0] m_cur = '0;   // {dcd, ri, dsr, cts} active
  logic [3:0] m_dlt = '0;

  always #2.5 clk = ~clk;

  modem_port_regs i_modem_port_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel_i(cpu_sel), .cpu_wr_i(cpu_wr), .cpu_rd_i(cpu_rd),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .irq_en_i(irq_en), .irq_o(irq), .drv_dis_o(drv_dis),
    .cts_n_i(pin_n[0]), .dsr_n_i(pin_n[1]), .ri_n_i(pin_n[2]), .dcd_n_i(pin_n[3]),
    .dtr_n_o(dtr_n), .rts_n_o(rts_n), .out1_n_o(out1_n), .out2_n_o(out2_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] src();
    if (m_ctl[4]) return {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]};
    return ~pin_n;
  endfunction

  task automatic model_step();
    logic [3:0] n;
    n = src();
    m_dlt[0] |= m_cur[0] ^ n[0];
    m_dlt[1] |= m_cur[1] ^ n[1];
    m_dlt[3] |= m_cur[3] ^ n[3];
    m_dlt[2] |= m_cur[2] & ~n[2];
    m_cur = n;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic write_ctl(input logic [4:0] v);
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b1; cpu_wdata = v;
    @(negedge clk);
    cpu_wr = 1'b0;
    m_ctl = v;
    model_step();
    settle();
  endtask

  task automatic set_pins(input logic [3:0] v);
    @(negedge clk);
    pin_n = v;
    model_step();
    settle();
  endtask

  task automatic read_reg(input logic sel, output logic [7:0] v);
    @(negedge clk);
    cpu_sel = sel; cpu_rd = 1'b1;
    #1;
    v = cpu_rdata;
    check("R10 drv_dis during read", {7'd0, drv_dis}, 8'd0);
    @(negedge clk);
    cpu_rd = 1'b0;
    #1;
    check("R10 drv_dis idle", {7'd0, drv_dis}, 8'd1);
  endtask

  // R4 R5 R6 R9 R7: check request, read, compare, check request drops
  task automatic check_status(input string req);
    logic [7:0] v;
    check({req, " R9 irq before read"}, {7'd0, irq}, {7'd0, irq_en & (|m_dlt)});
    read_reg(1'b1, v);
    check({req, " R4/R5/R6 status"}, v, {m_cur, m_dlt});
    m_dlt = '0;
    check({req, " R7/R9 irq after read"}, {7'd0, irq}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {4'd0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 drv_dis", {7'd0, drv_dis}, 8'd1);
    irq_en = 1'b1;
    check_status("R1");

    // R2 control bits drive inverted pins; control reads as zero
    for (int c = 0; c < 16; c++) begin
      write_ctl(5'(c));
      check("R2 pins", {4'd0, out2_n, out1_n, rts_n, dtr_n}, {4'd0, ~4'(c)});
    end
    read_reg(1'b0, v);
    check("R2 control reads zero", v, 8'd0);
    check_status("R2 no status effect");

    // R3 R8 loopback: outputs idle, status follows control bits
    for (int c = 0; c < 16; c++) begin
      irq_en = c[0];
      write_ctl(5'(c) | 5'h10);
      check("R3 pins idle", {4'd0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
      check_status("R8 loopback map");
    end
    // R8 external pins ignored while in loopback
    write_ctl(5'h15);
    check_status("R8 setup");
    for (int p = 0; p < 16; p++) begin
      @(negedge clk); pin_n = 4'(p); settle();
      check_status("R8 ext ignored");
    end
    set_pins(4'hF);
    write_ctl(5'h00);
    check_status("R8 exit loopback");

    // R4 R5 R6 R9 all pairs of external patterns
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        irq_en = b[0] ^ a[1];
        set_pins(4'(a));
        check_status("R5 step a");
        set_pins(4'(b));
        check_status("R6 step b");
      end
    end
    set_pins(4'hF);
    check_status("R5 park");

    // R5 sticky across several changes without a read
    irq_en = 1'b1;
    set_pins(4'hE);
    set_pins(4'hF);
    set_pins(4'hB);
    check_status("R5 sticky");
    set_pins(4'hF);
    check_status("R6 ring release");

    // R11 two-edge latency, then R7 read at the capturing edge
    @(negedge clk); pin_n = 4'hE;
    @(negedge clk); #1;
    check("R11 after one edge", cpu_rdata, 8'h00);
    @(negedge clk); #1;
    check("R11 after two edges", cpu_rdata, 8'h10);
    cpu_rd = 1'b1;
    #1;
    check("R7 read at change edge", cpu_rdata, 8'h10);
    @(negedge clk); cpu_rd = 1'b0;
    model_step();
    settle();
    check_status("R7 change kept");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule